// File: doc/BRIEF.md
# Rotate, Shift and Bit-Manipulation Unit

This block performs the byte-wide rotate, shift and single-bit operations of a small 8-bit processor datapath. Each cycle with `in_valid` high it takes an operand byte, the accumulator, a 4-bit operation code, a 3-bit bit index and the current flag byte. On the next clock edge it registers three results: the result byte, an accumulator value and a new flag byte.

The operations are grouped as follows. The general forms rotate or shift any operand and set the full flag set. The short accumulator-only rotate forms act on the accumulator input and touch only carry, half-carry and add/subtract. The two nibble rotates exchange 4-bit fields between the accumulator and a memory byte and leave carry alone. The bit test, bit set and bit reset operations act on one selected bit.

Operand fetch, memory writeback and instruction decoding belong to the surrounding datapath.

The flag byte layout is: sign bit 7, zero bit 6, half-carry bit 4, parity bit 2, add/subtract bit 1, carry bit 0. Parity is 1 when the byte holds an even number of ones.

Top module: `rsb_unit`

## Requirements
- R1: One cycle after a clock edge with `rst` high, `out_valid`, `result`, `acc_out` and `flags_out` are all zero.
- R2: Outputs are registered. The results of a transaction with `in_valid` high appear one cycle later, together with `out_valid` high. When `in_valid` is low, `out_valid` goes low on the next edge and the result outputs keep their previous values.
- R3: Circular rotate left (op 0) moves bit 7 into bit 0 and into carry. Circular rotate right (op 1) moves bit 0 into bit 7 and into carry.
- R4: Rotate left through carry (op 2) sends bit 7 to carry and the incoming carry to bit 0. Rotate right through carry (op 3) sends bit 0 to carry and the incoming carry to bit 7.
- R5: Arithmetic shift left (op 4) fills bit 0 with 0 and sends bit 7 to carry. Arithmetic shift right (op 5) keeps bit 7 and sends bit 0 to carry. Logical shift right (op 6) fills bit 7 with 0 and sends bit 0 to carry.
- R6: Ops 0 to 6 set sign, zero and parity from the result and clear half-carry and add/subtract.
- R7: The accumulator forms act on `acc_in`: ops 7, 8, 9 and 10 behave like ops 0, 1, 2 and 3. They drive the rotated value on both `result` and `acc_out`. They change carry, clear half-carry and add/subtract, and keep sign, zero and parity.
- R8: Nibble rotate left (op 11) gives result = {operand[3:0], acc[3:0]} and acc = {acc[7:4], operand[7:4]}. Nibble rotate right (op 12) gives result = {acc[3:0], operand[7:4]} and acc = {acc[7:4], operand[3:0]}.
- R9: Ops 11 and 12 set sign, zero and parity from the new accumulator, clear half-carry and add/subtract, and keep carry.
- R10: Bit test (op 13) returns the operand unchanged as the result. It sets zero when the bit chosen by `bit_sel` is 0, sets half-carry, clears add/subtract, and keeps carry, sign and parity.
- R11: Bit set (op 14) and bit reset (op 15) force the selected bit to 1 or 0 in the result and leave every flag bit unchanged.
- R12: Flag bits 5 and 3 always pass through from `flags_in`. For every op other than 7 to 12, `acc_out` equals `acc_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Transaction present this cycle |
| op | input | 4 | Operation code |
| operand | input | 8 | Operand byte (register or memory) |
| acc_in | input | 8 | Current accumulator |
| bit_sel | input | 3 | Bit index for test, set and reset |
| flags_in | input | 8 | Current flag byte |
| out_valid | output | 1 | Registered results are from a transaction |
| result | output | 8 | Result byte |
| acc_out | output | 8 | Updated accumulator |
| flags_out | output | 8 | Updated flag byte |

## Verification
Two functions can land in the same cycle. The nibble rotates write a new memory byte and a new accumulator together, and the accumulator rotate forms drive the same value onto both `result` and `acc_out`. The bench provokes both cases with operand and accumulator patterns whose nibbles all differ, so that a swapped or misrouted field shows up. Each clock it compares all three registered outputs at once against a behavioural model that computes them with integer arithmetic. The carry-preserving paths are stressed with incoming carry both set and clear.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  typedef enum logic [3:0] {
    OP_RLC  = 4'd0,  OP_RRC  = 4'd1,  OP_RL   = 4'd2,  OP_RR   = 4'd3,
    OP_SLA  = 4'd4,  OP_SRA  = 4'd5,  OP_SRL  = 4'd6,
    OP_RLCA = 4'd7,  OP_RRCA = 4'd8,  OP_RLA  = 4'd9,  OP_RRA  = 4'd10,
    OP_NRL  = 4'd11, OP_NRR  = 4'd12,
    OP_BTST = 4'd13, OP_BSET = 4'd14, OP_BCLR = 4'd15
  } rsb_op_e;

  typedef enum logic [2:0] {
    SK_RLC, SK_RRC, SK_RL, SK_RR, SK_SLA, SK_SRA, SK_SRL, SK_NONE
  } shift_kind_e;

  typedef enum logic [1:0] {BM_TEST, BM_SET, BM_CLR} bit_mode_e;

  localparam int FLG_S = 7;
  localparam int FLG_Z = 6;
  localparam int FLG_H = 4;
  localparam int FLG_P = 2;
  localparam int FLG_N = 1;
  localparam int FLG_C = 0;
  localparam int FLG_W = 8;
endpackage

// File: rtl/rsb_shift.sv
module rsb_shift
  import rsb_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] din,
  input  logic          cin,
  input  shift_kind_e   kind,
  output logic [DW-1:0] dout,
  output logic          cout
);
  localparam int MSB = DW - 1;

  always_comb begin
    dout = din;
    cout = cin;
    case (kind)
      SK_RLC: begin dout = {din[MSB-1:0], din[MSB]}; cout = din[MSB]; end
      SK_RRC: begin dout = {din[0], din[MSB:1]};     cout = din[0];   end
      SK_RL:  begin dout = {din[MSB-1:0], cin};      cout = din[MSB]; end
      SK_RR:  begin dout = {cin, din[MSB:1]};        cout = din[0];   end
      SK_SLA: begin dout = {din[MSB-1:0], 1'b0};     cout = din[MSB]; end
      SK_SRA: begin dout = {din[MSB], din[MSB:1]};   cout = din[0];   end
      SK_SRL: begin dout = {1'b0, din[MSB:1]};       cout = din[0];   end
      default: begin dout = din; cout = cin; end
    endcase
  end
endmodule

// File: rtl/rsb_nibble.sv
module rsb_nibble #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] mem_in,
  input  logic [DW-1:0] acc_in,
  input  logic          dir_right,
  output logic [DW-1:0] mem_out,
  output logic [DW-1:0] acc_out
);
  localparam int NW = DW / 2;

  logic [NW-1:0] m_hi, m_lo, a_hi, a_lo;
  assign m_hi = mem_in[DW-1:NW];
  assign m_lo = mem_in[NW-1:0];
  assign a_hi = acc_in[DW-1:NW];
  assign a_lo = acc_in[NW-1:0];

  always_comb begin
    if (dir_right) begin
      mem_out = {a_lo, m_hi};
      acc_out = {a_hi, m_lo};
    end else begin
      mem_out = {m_lo, a_lo};
      acc_out = {a_hi, m_hi};
    end
  end
endmodule

// File: rtl/rsb_bitop.sv
module rsb_bitop
  import rsb_pkg::*;
#(
  parameter int DW = 8,
  localparam int SW = $clog2(DW)
) (
  input  logic [DW-1:0] din,
  input  logic [SW-1:0] sel,
  input  bit_mode_e     mode,
  output logic [DW-1:0] dout,
  output logic          bit_val
);
  logic [DW-1:0] mask;

  for (genvar i = 0; i < DW; i++) begin : g_mask
    assign mask[i] = (sel == SW'(i));
  end

  assign bit_val = |(din & mask);

  always_comb begin
    case (mode)
      BM_SET:  dout = din | mask;
      BM_CLR:  dout = din & ~mask;
      default: dout = din;
    endcase
  end
endmodule

// File: rtl/rsb_unit.sv
module rsb_unit
  import rsb_pkg::*;
#(
  parameter int DW = 8,
  localparam int SW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [3:0]    op,
  input  logic [DW-1:0] operand,
  input  logic [DW-1:0] acc_in,
  input  logic [SW-1:0] bit_sel,
  input  logic [7:0]    flags_in,
  output logic          out_valid,
  output logic [DW-1:0] result,
  output logic [DW-1:0] acc_out,
  output logic [7:0]    flags_out
);
  rsb_op_e       opc;
  logic          is_gen, is_acc, is_nib, is_bit;
  shift_kind_e   kind;
  bit_mode_e     bmode;
  logic [DW-1:0] sh_in, sh_out, nb_mem, nb_acc, bt_out;
  logic          sh_c, bt_val;
  logic [DW-1:0] nxt_res, nxt_acc;
  logic [FLG_W-1:0] nxt_flg;

  always_comb begin
    opc    = rsb_op_e'(op);
    is_gen = opc inside {OP_RLC, OP_RRC, OP_RL, OP_RR, OP_SLA, OP_SRA, OP_SRL};
    is_acc = opc inside {OP_RLCA, OP_RRCA, OP_RLA, OP_RRA};
    is_nib = opc inside {OP_NRL, OP_NRR};
    is_bit = opc inside {OP_BTST, OP_BSET, OP_BCLR};
    case (opc)
      OP_RLC, OP_RLCA: kind = SK_RLC;
      OP_RRC, OP_RRCA: kind = SK_RRC;
      OP_RL,  OP_RLA:  kind = SK_RL;
      OP_RR,  OP_RRA:  kind = SK_RR;
      OP_SLA:          kind = SK_SLA;
      OP_SRA:          kind = SK_SRA;
      OP_SRL:          kind = SK_SRL;
      default:         kind = SK_NONE;
    endcase
    case (opc)
      OP_BSET: bmode = BM_SET;
      OP_BCLR: bmode = BM_CLR;
      default: bmode = BM_TEST;
    endcase
    sh_in = is_acc ? acc_in : operand;
  end

  rsb_shift #(.DW(DW)) u_shift (
    .din(sh_in), .cin(flags_in[FLG_C]), .kind(kind),
    .dout(sh_out), .cout(sh_c)
  );

  rsb_nibble #(.DW(DW)) u_nibble (
    .mem_in(operand), .acc_in(acc_in), .dir_right(opc == OP_NRR),
    .mem_out(nb_mem), .acc_out(nb_acc)
  );

  rsb_bitop #(.DW(DW)) u_bitop (
    .din(operand), .sel(bit_sel), .mode(bmode),
    .dout(bt_out), .bit_val(bt_val)
  );

  always_comb begin
    nxt_res = operand;
    nxt_acc = acc_in;
    nxt_flg = flags_in;
    if (is_gen) begin
      nxt_res        = sh_out;
      nxt_flg[FLG_S] = sh_out[DW-1];
      nxt_flg[FLG_Z] = ~|sh_out;
      nxt_flg[FLG_P] = ~^sh_out;
      nxt_flg[FLG_H] = 1'b0;
      nxt_flg[FLG_N] = 1'b0;
      nxt_flg[FLG_C] = sh_c;
    end else if (is_acc) begin
      nxt_res        = sh_out;
      nxt_acc        = sh_out;
      nxt_flg[FLG_H] = 1'b0;
      nxt_flg[FLG_N] = 1'b0;
      nxt_flg[FLG_C] = sh_c;
    end else if (is_nib) begin
      nxt_res        = nb_mem;
      nxt_acc        = nb_acc;
      nxt_flg[FLG_S] = nb_acc[DW-1];
      nxt_flg[FLG_Z] = ~|nb_acc;
      nxt_flg[FLG_P] = ~^nb_acc;
      nxt_flg[FLG_H] = 1'b0;
      nxt_flg[FLG_N] = 1'b0;
    end else if (is_bit) begin
      nxt_res = bt_out;
      if (bmode == BM_TEST) begin
        nxt_flg[FLG_Z] = ~bt_val;
        nxt_flg[FLG_H] = 1'b1;
        nxt_flg[FLG_N] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      acc_out   <= '0;
      flags_out <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= nxt_res;
        acc_out   <= nxt_acc;
        flags_out <= nxt_flg;
      end
    end
  end
endmodule

// File: rtl/rsb_unit_chk.sv
module rsb_unit_chk #(
  parameter int DW = 8,
  localparam int SW = $clog2(DW)
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [3:0]    op,
  input logic [DW-1:0] operand,
  input logic [DW-1:0] acc_in,
  input logic [SW-1:0] bit_sel,
  input logic [7:0]    flags_in,
  input logic          out_valid,
  input logic [DW-1:0] result,
  input logic [DW-1:0] acc_out,
  input logic [7:0]    flags_out
);
  localparam int NW = DW / 2;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0 && flags_out == '0));

  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result) && $stable(acc_out)));

  assert_acc_form_keep_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op >= 4'd7 && op <= 4'd10) |=>
      (result == acc_out && flags_out[7] == $past(flags_in[7]) &&
       flags_out[6] == $past(flags_in[6]) && flags_out[2] == $past(flags_in[2]) &&
       !flags_out[4] && !flags_out[1]));

  assert_nib_carry_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op == 4'd11 || op == 4'd12)) |=>
      (flags_out[0] == $past(flags_in[0]) &&
       acc_out[DW-1:NW] == $past(acc_in[DW-1:NW])));

  assert_bit_test_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 4'd13) |=>
      (flags_out[6] == !$past(operand[bit_sel]) && flags_out[4] && !flags_out[1] &&
       flags_out[0] == $past(flags_in[0]) && result == $past(operand)));

  assert_setclr_flags_R11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op == 4'd14 || op == 4'd15)) |=> (flags_out == $past(flags_in)));

  assert_spare_flags_R12: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (flags_out[5] == $past(flags_in[5]) && flags_out[3] == $past(flags_in[3])));
endmodule

bind rsb_unit rsb_unit_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .operand(operand),
  .acc_in(acc_in), .bit_sel(bit_sel), .flags_in(flags_in),
  .out_valid(out_valid), .result(result), .acc_out(acc_out), .flags_out(flags_out)
);

// File: tb/tb_rsb_unit.sv
module tb_rsb_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [3:0] op = '0;
  logic [7:0] operand = '0;
  logic [7:0] acc_in = '0;
  logic [2:0] bit_sel = '0;
  logic [7:0] flags_in = '0;
  logic       out_valid;
  logic [7:0] result, acc_out, flags_out;

  int tests = 0;
  int fails = 0;
  logic [23:0] exp_bus = '0;
  logic        exp_valid = 1'b0;
  string       exp_tag = "R1";
  logic [7:0]  pats [8] = '{8'h00, 8'h80, 8'h01, 8'hFF, 8'hA5, 8'h5A, 8'h7E, 8'h12};
  logic [7:0]  flgs [4] = '{8'h00, 8'hFF, 8'h29, 8'hD6};

  always #2 clk = ~clk;

  rsb_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .operand(operand),
    .acc_in(acc_in), .bit_sel(bit_sel), .flags_in(flags_in),
    .out_valid(out_valid), .result(result), .acc_out(acc_out), .flags_out(flags_out)
  );

  function automatic int ones(input int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return n;
  endfunction

  function automatic logic [23:0] model(input int o, input int x, input int a,
                                        input int b, input logic [7:0] f);
    int r = x, na = a, c = f[0], src;
    logic [7:0] nf = f;
    if (o >= 7 && o <= 10) begin
      src = a;
      case (o)
        7:  begin c = src / 128; r = (src * 2) % 256 + c; end
        8:  begin c = src % 2;   r = src / 2 + c * 128;   end
        9:  begin r = (src * 2) % 256 + f[0]; c = src / 128; end
        default: begin r = src / 2 + f[0] * 128; c = src % 2; end
      endcase
      na = r;
      nf[4] = 0; nf[1] = 0; nf[0] = c[0];
    end else if (o <= 6) begin
      case (o)
        0: begin c = x / 128; r = (x * 2) % 256 + c; end
        1: begin c = x % 2;   r = x / 2 + c * 128;   end
        2: begin r = (x * 2) % 256 + f[0]; c = x / 128; end
        3: begin r = x / 2 + f[0] * 128; c = x % 2; end
        4: begin c = x / 128; r = (x * 2) % 256; end
        5: begin c = x % 2;   r = x / 2 + (x / 128) * 128; end
        default: begin c = x % 2; r = x / 2; end
      endcase
      nf[7] = (r >= 128); nf[6] = (r == 0); nf[2] = (ones(r) % 2 == 0);
      nf[4] = 0; nf[1] = 0; nf[0] = c[0];
    end else if (o == 11 || o == 12) begin
      if (o == 11) begin r = (x % 16) * 16 + a % 16; na = (a / 16) * 16 + x / 16; end
      else         begin r = (a % 16) * 16 + x / 16; na = (a / 16) * 16 + x % 16; end
      nf[7] = (na >= 128); nf[6] = (na == 0); nf[2] = (ones(na) % 2 == 0);
      nf[4] = 0; nf[1] = 0;
    end else if (o == 13) begin
      nf[6] = (((x >> b) & 1) == 0); nf[4] = 1; nf[1] = 0;
    end else if (o == 14) begin
      r = x | (1 << b);
    end else begin
      r = x & ~(1 << b) & 255;
    end
    return {r[7:0], na[7:0], nf};
  endfunction

  function automatic string tag_of(input int o);
    if (o <= 1) return "R3 R6 R12";
    if (o <= 3) return "R4 R6 R12";
    if (o <= 6) return "R5 R6 R12";
    if (o <= 10) return "R7";
    if (o <= 12) return "R8 R9";
    if (o == 13) return "R10 R12";
    return "R11 R12";
  endfunction

  task automatic compare();
    tests++;
    if ({result, acc_out, flags_out} !== exp_bus || out_valid !== exp_valid) begin
      fails++;
      $display("FAIL %s: got v=%0b res=%h acc=%h flg=%h, expected v=%0b res=%h acc=%h flg=%h",
               exp_tag, out_valid, result, acc_out, flags_out,
               exp_valid, exp_bus[23:16], exp_bus[15:8], exp_bus[7:0]);
    end
  endtask

  task automatic step(input logic v, input int o, input int x, input int a,
                      input int b, input logic [7:0] f);
    @(negedge clk);
    compare();
    exp_valid = v;
    if (v) begin
      exp_bus = model(o, x, a, b, f);
      exp_tag = tag_of(o);
    end else begin
      exp_tag = "R2";
    end
    in_valid = v;
    op       = 4'(o);
    operand  = 8'(x);
    acc_in   = 8'(a);
    bit_sel  = 3'(b);
    flags_in = f;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got hang, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: first compare checks the reset state
    for (int o = 0; o < 16; o++) begin
      for (int i = 0; i < 8; i++) begin
        step(1'b1, o, pats[i], pats[(i + 3) % 8], i, flgs[(i + o) % 4]);
      end
      // R2: idle cycle must hold the previous results
      step(1'b0, 0, 8'h3C, 8'hC3, 0, 8'h00);
    end
    // R8: distinct nibbles on both bytes
    step(1'b1, 11, 8'h12, 8'h34, 0, 8'h01);
    step(1'b1, 12, 8'h12, 8'h34, 0, 8'h00);
    step(1'b1, 11, 8'h00, 8'h00, 0, 8'h01);
    for (int k = 0; k < 400; k++) begin
      step(($urandom % 5) != 0, $urandom % 16, $urandom % 256, $urandom % 256,
           $urandom % 8, 8'($urandom));
    end
    // reset mid-run: R1
    @(negedge clk);
    compare();
    rst = 1'b1; in_valid = 1'b0;
    exp_bus = '0; exp_valid = 1'b0; exp_tag = "R1";
    @(negedge clk);
    rst = 1'b0;
    step(1'b0, 0, 0, 0, 0, 8'h00);
    step(1'b0, 0, 0, 0, 0, 8'h00);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule